// File: doc/BRIEF.md
# Indirect PHY Register Access Engine

This block gives a controller a plain request port for reading and writing the 16-bit-addressed configuration space of a SerDes. That space cannot be reached directly. Only a trio of registers (control, address and data) leads into it, and the trio itself sits behind a paged memory-mapped window. The engine turns each request into the full handshake. It writes the page word for every window access, polls the busy bit with a fixed pause between polls, loads the target address, and issues the start command. For reads it also fetches the result.

The requester supplies a 5-bit device number, a lane index, a 16-bit register address and, for writes, 16-bit data. The lane index moves the target address by a fixed per-lane stride. The result comes back as a single-cycle `done` pulse. Read data is valid in that same cycle, and `timeout` marks a request that gave up because the PHY stayed busy. On the downstream side the engine drives a single-cycle register bus master. Read data on that bus is returned combinationally while `bus_re` is high.

Top module: `phy_cfg_access`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after release until a request is accepted, `done`, `timeout`, `bus_we` and `bus_re` are all low.
- R2: Every window access is immediately preceded, in the previous cycle, by a page write to bus address 0x800. The page data is {device[4:0] in bits 11:7, register address bits 15:9 in bits 6:0}. The access itself uses bus address (register address bits 8:0) shifted left by 2.
- R3: The trio lives at PHY addresses 0x80A0 (control), 0x80A1 (address) and 0x80A2 (data). On a control read, bit 0 is busy. On a control write, bit 0 is start and bit 1 selects write (1) or read (0), so a read start writes 0x0001 and a write start writes 0x0003.
- R4: A read performs these steps in order: poll control until not busy; write the target address to the address register; write a read start to control; poll until not busy; read the data register. That value is returned on `rdata`. `bus_rdata` is taken in the same cycle as `bus_re`.
- R5: A write performs these steps in order: poll until not busy; write the address register; write `req_wdata` to the data register; write a write start to control. It then finishes without polling again.
- R6: After a poll that reads busy, the bus stays idle for exactly POLL_GAP cycles before the next page write.
- R7: If MAX_POLLS consecutive polls in one polling phase all read busy, the request ends at once with `done` and `timeout` both high and `rdata` zero, and no further bus access follows. A phase whose poll number MAX_POLLS reads not-busy completes normally.
- R8: The address written to the address register is `req_addr + req_lane * 0x100`.
- R9: A request is taken only while idle. `req_valid` raised during a transaction has no effect. `done` is high for exactly one cycle. `rdata` is the fetched value on a successful read and zero on a write.
- R10: `bus_we` and `bus_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_dev | input | 5 | PHY device number |
| req_lane | input | 2 | Lane index |
| req_addr | input | 16 | PHY register base address |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Busy-poll limit exceeded, valid with done |
| rdata | output | 16 | Read result, valid with done |
| bus_addr | output | 12 | Window byte address |
| bus_we | output | 1 | Window write strobe |
| bus_re | output | 1 | Window read strobe |
| bus_wdata | output | 16 | Window write data |
| bus_rdata | input | 16 | Window read data, same cycle as bus_re |

## Verification
On every cycle, the assertions check four things: the two bus strobes are exclusive, each window access follows a page write, `done` lasts one cycle, and `timeout` appears only with `done`. The poll counter is also checked against its limit. The order and content of the steps, the page word, the lane-shifted target, the idle gap after a busy poll, the timeout boundary at exactly MAX_POLLS, and the dropping of requests made mid-transaction can only be shown by the scenarios. In those scenarios a modelled PHY stays busy for chosen counts, and a scoreboard matches every bus operation and every result.

// File: rtl/phy_cfg_pkg.sv
// Shared constants and types for the indirect PHY register access engine.
// Assumes the three trio registers share one page (same address bits 15:9).
package phy_cfg_pkg;
    localparam logic [15:0] TRIO_CTL  = 16'h80A0;
    localparam logic [15:0] TRIO_ADDR = 16'h80A1;
    localparam logic [15:0] TRIO_DATA = 16'h80A2;
    localparam int BUSY_BIT  = 0;
    localparam int START_BIT = 0;
    localparam int WRITE_BIT = 1;
    localparam int PAGE_LSB  = 9;

    typedef enum logic [1:0] {ST_IDLE, ST_PAGE, ST_ACCESS, ST_GAP} seq_state_t;
    typedef enum logic [2:0] {
        STEP_POLL_PRE, STEP_SET_ADDR, STEP_SET_DATA,
        STEP_START, STEP_POLL_POST, STEP_FETCH
    } seq_step_t;
endpackage

// File: rtl/phy_cfg_addr_map.sv
// Splits a PHY register address into the page word and the window byte offset.
// Assumes DEV_W + AW - PAGE_LSB <= BUS_AW and PAGE_LSB + 2 <= BUS_AW.
module phy_cfg_addr_map
    import phy_cfg_pkg::*;
#(
    parameter int DEV_W  = 5,
    parameter int AW     = 16,
    parameter int BUS_AW = 12
) (
    input  logic [DEV_W-1:0]  dev,
    input  logic [AW-1:0]     reg_addr,
    output logic [BUS_AW-1:0] page_word,
    output logic [BUS_AW-1:0] offset
);
    localparam int PW = DEV_W + AW - PAGE_LSB;
    localparam int OW = PAGE_LSB + 2;

    logic [PW-1:0] page_full;
    logic [OW-1:0] ofs_full;

    // Page word: device above the upper address bits; offset: word-aligned low bits.
    always_comb begin
        page_full = {dev, reg_addr[AW-1:PAGE_LSB]};
        ofs_full  = {reg_addr[PAGE_LSB-1:0], 2'b00};
    end

    assign page_word = BUS_AW'(page_full);
    assign offset    = BUS_AW'(ofs_full);
endmodule

// File: rtl/phy_cfg_gap.sv
// Pause timer between busy polls: expired rises on the GAP_CYCLES-th cycle of run.
// Assumes GAP_CYCLES >= 1 and that run drops for at least one cycle between pauses.
module phy_cfg_gap #(
    parameter int GAP_CYCLES = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES + 1);

    logic [CW-1:0] cnt;

    // Count cycles while running, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (run) cnt <= cnt + 1'b1;
        else          cnt <= '0;
    end

    assign expired = run && (cnt == CW'(GAP_CYCLES - 1));
endmodule

// File: rtl/phy_cfg_seq.sv
// Sequencer: walks each request through page write / window access pairs,
// busy polling with pauses and a bounded poll count. Assumes bus_rdata is
// valid in the cycle bus_re is high and that DW >= BUS_AW.
module phy_cfg_seq
    import phy_cfg_pkg::*;
#(
    parameter int DEV_W       = 5,
    parameter int LANE_W      = 2,
    parameter int AW          = 16,
    parameter int DW          = 16,
    parameter int BUS_AW      = 12,
    parameter int LANE_STRIDE = 256,
    parameter int MAX_POLLS   = 1000,
    parameter logic [BUS_AW-1:0] WINDOW_OFS = 12'h800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [LANE_W-1:0] req_lane,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              done,
    output logic              timeout,
    output logic [DW-1:0]     rdata,
    output logic              gap_run,
    input  logic              gap_expired,
    output logic [DEV_W-1:0]  cur_dev,
    output logic [AW-1:0]     cur_reg,
    input  logic [BUS_AW-1:0] page_word,
    input  logic [BUS_AW-1:0] offset,
    output logic [BUS_AW-1:0] bus_addr,
    output logic              bus_we,
    output logic              bus_re,
    output logic [DW-1:0]     bus_wdata,
    input  logic [DW-1:0]     bus_rdata
);
    localparam int LANE_SHIFT = $clog2(LANE_STRIDE);
    localparam int PCW = $clog2(MAX_POLLS + 1);

    seq_state_t       state;
    seq_step_t        step, step_next;
    logic             is_write_q;
    logic [DEV_W-1:0] dev_q;
    logic [AW-1:0]    target_q;
    logic [DW-1:0]    wdata_q;
    logic [PCW-1:0]   polls;
    logic             acc_rd, is_poll, finish, busy;
    logic [DW-1:0]    acc_val;

    // Decode the current step: trio register, direction and outgoing value.
    always_comb begin
        cur_reg = TRIO_CTL;
        acc_val = '0;
        acc_rd  = 1'b1;
        case (step)
            STEP_SET_ADDR: begin cur_reg = TRIO_ADDR; acc_val = target_q; acc_rd = 1'b0; end
            STEP_SET_DATA: begin cur_reg = TRIO_DATA; acc_val = wdata_q;  acc_rd = 1'b0; end
            STEP_START: begin
                acc_rd = 1'b0;
                acc_val[START_BIT] = 1'b1;
                acc_val[WRITE_BIT] = is_write_q;
            end
            STEP_FETCH: cur_reg = TRIO_DATA;
            default: ;
        endcase
    end

    // Step ordering after a successful access.
    always_comb begin
        step_next = STEP_FETCH;
        case (step)
            STEP_POLL_PRE:  step_next = STEP_SET_ADDR;
            STEP_SET_ADDR:  step_next = is_write_q ? STEP_SET_DATA : STEP_START;
            STEP_SET_DATA:  step_next = STEP_START;
            STEP_START:     step_next = STEP_POLL_POST;
            default:        step_next = STEP_FETCH;
        endcase
    end

    assign is_poll = (step == STEP_POLL_PRE) || (step == STEP_POLL_POST);
    assign finish  = (step == STEP_FETCH) || (step == STEP_START && is_write_q);
    assign busy    = bus_rdata[BUSY_BIT];
    assign cur_dev = dev_q;
    assign gap_run = (state == ST_GAP);

    // Drive the register bus from the state: page write, then the access.
    always_comb begin
        bus_we    = 1'b0;
        bus_re    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        if (state == ST_PAGE) begin
            bus_we    = 1'b1;
            bus_addr  = WINDOW_OFS;
            bus_wdata = DW'(page_word);
        end else if (state == ST_ACCESS) begin
            bus_addr  = offset;
            bus_we    = !acc_rd;
            bus_re    = acc_rd;
            bus_wdata = acc_rd ? '0 : acc_val;
        end
    end

    // Main sequencer: capture, page/access pairs, busy pauses, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            step       <= STEP_POLL_PRE;
            is_write_q <= 1'b0;
            dev_q      <= '0;
            target_q   <= '0;
            wdata_q    <= '0;
            polls      <= '0;
            done       <= 1'b0;
            timeout    <= 1'b0;
            rdata      <= '0;
        end else begin
            done    <= 1'b0;
            timeout <= 1'b0;
            case (state)
                ST_IDLE: if (req_valid) begin
                    is_write_q <= req_write;
                    dev_q      <= req_dev;
                    target_q   <= req_addr + (AW'(req_lane) << LANE_SHIFT);
                    wdata_q    <= req_wdata;
                    step       <= STEP_POLL_PRE;
                    polls      <= '0;
                    state      <= ST_PAGE;
                end
                ST_PAGE: state <= ST_ACCESS;
                ST_ACCESS: begin
                    if (is_poll && busy) begin
                        if (polls == PCW'(MAX_POLLS - 1)) begin
                            done    <= 1'b1;
                            timeout <= 1'b1;
                            rdata   <= '0;
                            state   <= ST_IDLE;
                        end else begin
                            polls <= polls + 1'b1;
                            state <= ST_GAP;
                        end
                    end else if (finish) begin
                        done  <= 1'b1;
                        rdata <= is_write_q ? '0 : bus_rdata;
                        state <= ST_IDLE;
                    end else begin
                        step  <= step_next;
                        polls <= '0;
                        state <= ST_PAGE;
                    end
                end
                ST_GAP: if (gap_expired) state <= ST_PAGE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_re));
    // R2
    page_before_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_we || bus_re) && bus_addr != WINDOW_OFS) |->
            $past(bus_we && bus_addr == WINDOW_OFS));
    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    timeout_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> done);
    // R7
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        polls < PCW'(MAX_POLLS));
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!done && !bus_we && !bus_re));
endmodule

// File: rtl/phy_cfg_access.sv
// Top: indirect PHY register access engine. Joins the sequencer, the address
// splitter and the poll pause timer. Assumes a single-cycle register bus slave.
module phy_cfg_access #(
    parameter int DEV_W       = 5,
    parameter int LANE_W      = 2,
    parameter int AW          = 16,
    parameter int DW          = 16,
    parameter int BUS_AW      = 12,
    parameter int LANE_STRIDE = 256,
    parameter int POLL_GAP    = 250,
    parameter int MAX_POLLS   = 1000,
    parameter logic [BUS_AW-1:0] WINDOW_OFS = 12'h800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [LANE_W-1:0] req_lane,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              done,
    output logic              timeout,
    output logic [DW-1:0]     rdata,
    output logic [BUS_AW-1:0] bus_addr,
    output logic              bus_we,
    output logic              bus_re,
    output logic [DW-1:0]     bus_wdata,
    input  logic [DW-1:0]     bus_rdata
);
    logic              gap_run, gap_expired;
    logic [DEV_W-1:0]  cur_dev;
    logic [AW-1:0]     cur_reg;
    logic [BUS_AW-1:0] page_word, offset;

    phy_cfg_seq #(
        .DEV_W(DEV_W), .LANE_W(LANE_W), .AW(AW), .DW(DW), .BUS_AW(BUS_AW),
        .LANE_STRIDE(LANE_STRIDE), .MAX_POLLS(MAX_POLLS), .WINDOW_OFS(WINDOW_OFS)
    ) seq_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_dev(req_dev),
        .req_lane(req_lane), .req_addr(req_addr), .req_wdata(req_wdata),
        .done(done), .timeout(timeout), .rdata(rdata),
        .gap_run(gap_run), .gap_expired(gap_expired),
        .cur_dev(cur_dev), .cur_reg(cur_reg),
        .page_word(page_word), .offset(offset),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    phy_cfg_addr_map #(.DEV_W(DEV_W), .AW(AW), .BUS_AW(BUS_AW)) map_i (
        .dev(cur_dev), .reg_addr(cur_reg), .page_word(page_word), .offset(offset)
    );

    phy_cfg_gap #(.GAP_CYCLES(POLL_GAP)) gap_i (
        .clk(clk), .rst_n(rst_n), .run(gap_run), .expired(gap_expired)
    );
endmodule

// File: tb/phy_cfg_access_tb_top.sv
`timescale 1ns/1ps
module phy_cfg_access_tb_top;
    localparam int GAP = 4;
    localparam int MAXP = 6;
    localparam logic [15:0] KEY = 16'hA5C3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [4:0]  req_dev = '0;
    logic [1:0]  req_lane = '0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        done, timeout;
    logic [15:0] rdata;
    logic [11:0] bus_addr;
    logic        bus_we, bus_re;
    logic [15:0] bus_wdata, bus_rdata;

    int checks = 0, fails = 0, res_cnt = 0, idle = 0;
    bit gap_pending = 0;
    int pre_cfg = 0, post_cfg = 0;
    logic        m_phase;
    int          m_rdcnt;
    logic [15:0] m_addr, m_data;

    logic [28:0] exp_op[$];
    string       op_tag[$];
    logic [16:0] exp_res[$];
    string       res_tag[$];

    always #2 clk = ~clk;

    phy_cfg_access #(.POLL_GAP(GAP), .MAX_POLLS(MAXP)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_dev(req_dev), .req_lane(req_lane), .req_addr(req_addr),
        .req_wdata(req_wdata), .done(done), .timeout(timeout), .rdata(rdata),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // PHY model: busy for pre_cfg polls before start, post_cfg polls after.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase <= 1'b0; m_rdcnt <= 0; m_addr <= '0; m_data <= '0;
        end else begin
            if (done) begin m_phase <= 1'b0; m_rdcnt <= 0; end
            if (bus_re && bus_addr == 12'h280) m_rdcnt <= m_rdcnt + 1;
            if (bus_we && bus_addr == 12'h284) m_addr <= bus_wdata;
            if (bus_we && bus_addr == 12'h280 && bus_wdata[0]) begin
                m_phase <= 1'b1; m_rdcnt <= 0;
                if (!bus_wdata[1]) m_data <= m_addr ^ KEY;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_re && bus_addr == 12'h280)
            bus_rdata[0] = m_phase ? (m_rdcnt < post_cfg) : (m_rdcnt < pre_cfg);
        else if (bus_re && bus_addr == 12'h288)
            bus_rdata = m_data;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every bus operation and every result.
    always @(negedge clk) begin
        if (rst_n && (bus_we || bus_re)) begin
            if (gap_pending) check(idle == GAP, "R6", "idle cycles after busy poll", idle, GAP);
            gap_pending = bus_re && bus_addr == 12'h280 && bus_rdata[0];
            idle = 0;
            if (exp_op.size() == 0) begin
                check(0, "R9", "unexpected bus op", {bus_we, 3'b0, bus_addr, bus_wdata}, 0);
            end else begin
                logic [28:0] e;
                string t;
                e = exp_op.pop_front();
                t = op_tag.pop_front();
                check(bus_we == e[28] && bus_addr == e[27:16] &&
                      (!bus_we || bus_wdata == e[15:0]), t, "bus op",
                      {bus_we, 3'b0, bus_addr, bus_wdata}, {e[28], 3'b0, e[27:0]});
            end
        end else begin
            idle++;
        end
        if (rst_n && done) begin
            gap_pending = 0;
            check(exp_op.size() == 0, "R4", "ops left at done", exp_op.size(), 0);
            if (exp_res.size() == 0) begin
                check(0, "R9", "unexpected done", {timeout, rdata}, 0);
            end else begin
                logic [16:0] r;
                string t;
                r = exp_res.pop_front();
                t = res_tag.pop_front();
                check({timeout, rdata} == r, t, "result {timeout,rdata}", {timeout, rdata}, r);
            end
            res_cnt++;
        end
    end

    task automatic push_op(input bit we, input logic [11:0] a, input logic [15:0] d, input string t);
        exp_op.push_back({we, a, d});
        op_tag.push_back(t);
    endtask

    // Pushes the polls of one phase; returns 1 if the phase times out.
    task automatic push_polls(input int nbusy, input logic [15:0] pg, output bit tmo);
        int n;
        n = (nbusy >= MAXP) ? MAXP : nbusy + 1;
        tmo = (nbusy >= MAXP);
        for (int i = 0; i < n; i++) begin
            push_op(1'b1, 12'h800, pg, "R2");
            push_op(1'b0, 12'h280, 16'h0, "R3");
        end
    endtask

    task automatic run_req(input bit wr, input logic [4:0] dev, input logic [1:0] lane,
                           input logic [15:0] addr, input logic [15:0] wd,
                           input int pre, input int post, input bit poke, input string tag);
        logic [15:0] pg, tgt;
        bit tmo;
        int target;
        pg  = {4'b0, dev, 7'h40};
        tgt = addr + {6'b0, lane, 8'h00};
        pre_cfg = pre; post_cfg = post;
        push_polls(pre, pg, tmo);
        if (tmo) begin
            exp_res.push_back({1'b1, 16'h0}); res_tag.push_back("R7");
        end else begin
            push_op(1'b1, 12'h800, pg, "R2");
            push_op(1'b1, 12'h284, tgt, "R8");
            if (wr) begin
                push_op(1'b1, 12'h800, pg, "R2");
                push_op(1'b1, 12'h288, wd, "R5");
            end
            push_op(1'b1, 12'h800, pg, "R2");
            push_op(1'b1, 12'h280, wr ? 16'h0003 : 16'h0001, "R3");
            if (wr) begin
                exp_res.push_back({1'b0, 16'h0}); res_tag.push_back(tag);
            end else begin
                push_polls(post, pg, tmo);
                if (tmo) begin
                    exp_res.push_back({1'b1, 16'h0}); res_tag.push_back("R7");
                end else begin
                    push_op(1'b1, 12'h800, pg, "R2");
                    push_op(1'b0, 12'h288, 16'h0, "R4");
                    exp_res.push_back({1'b0, tgt ^ KEY}); res_tag.push_back(tag);
                end
            end
        end
        target = res_cnt + 1;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_dev = dev; req_lane = lane;
        req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            // R9: request while busy must be ignored
            req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h1111; req_wdata = 16'h5555;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (res_cnt < target) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(!done && !timeout && !bus_we && !bus_re, "R1", "outputs in reset",
              {done, timeout, bus_we, bus_re}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!done && !timeout && !bus_we && !bus_re, "R1", "outputs after reset",
              {done, timeout, bus_we, bus_re}, 0);
        run_req(1'b0, 5'd3,  2'd0, 16'h2002, 16'h0,    0, 0, 1'b0, "R4");
        run_req(1'b1, 5'd17, 2'd2, 16'h2004, 16'hBEEF, 0, 0, 1'b0, "R5");
        run_req(1'b0, 5'd31, 2'd3, 16'h20FF, 16'h0,    2, 3, 1'b0, "R8");
        run_req(1'b1, 5'd9,  2'd1, 16'h2005, 16'h1234, MAXP-1, 0, 1'b0, "R7");
        run_req(1'b0, 5'd5,  2'd0, 16'h2001, 16'h0,    MAXP, 0, 1'b0, "R7");
        run_req(1'b0, 5'd6,  2'd1, 16'h2002, 16'h0,    0, 100, 1'b0, "R7");
        run_req(1'b0, 5'd12, 2'd2, 16'h3C00, 16'h0,    2, 0, 1'b1, "R9");
        run_req(1'b0, 5'd0,  2'd0, 16'hFFFF, 16'h0,    0, MAXP-1, 1'b0, "R4");
        check(exp_res.size() == 0, "R9", "results outstanding", exp_res.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule